// File: doc/BRIEF.md
# Invalidation-Acknowledge Collector

This block sits on the requesting side of a directory-based coherence protocol with early exclusive replies. When the local cache misses on a write, it issues a read-exclusive request and allocates an entry here. The home node answers with the line data and a count of how many sharers it told to invalidate. The sharers then send their acknowledgements straight to the requester. Each entry tracks one such pending miss, matched by line address. The local core may use the line as soon as the data arrives.

Until the last acknowledgement has come in, the entry holds off two things. Forwarded requests from other nodes that target the line are parked in a small queue kept for each entry. A writeback or victimisation of the line is refused through a combinational stall output. When the acknowledgement total matches the count from the data reply, the entry completes and the line becomes write-owned. Any parked forwarded requests are then released one per cycle, oldest first. Acknowledgements may arrive before the data reply, so the count per entry is signed. An acknowledgement that matches no pending entry is flagged as an error.

Top module: `iac_collector`

## Requirements
- R1: `alloc_rdy` is high while at least one entry is free. `alloc_idx` gives the lowest-numbered free entry. A miss is taken into that entry on a cycle with `alloc_vld` and `alloc_rdy` both high. With every entry busy, `alloc_rdy` is low.
- R2: A data reply whose `data_addr` matches an entry that is waiting for data produces a one-cycle `grant_vld` pulse in the following cycle, with `grant_addr` equal to that address. From then on the core may use the line.
- R3: An entry completes in the cycle where it has its data reply and its acknowledgement total equals the delivered `data_cnt`. Acknowledgements may come before or after the data. Bit i of `inst_mask` pulses for one cycle in the cycle after entry i completes.
- R4: A data reply with a count of zero, on an entry that has received no early acknowledgements, completes in that same cycle. `wb_stall` is never raised for that line.
- R5: `wb_stall` is high, in the same cycle, exactly when `wb_vld` is high and `wb_addr` matches an entry that has its data but is still short of acknowledgements. Before the data arrives, and after completion, a writeback of the line is not stalled.
- R6: A forwarded request whose `fwd_addr` matches a held line (data in, acknowledgements short) is accepted (`fwd_rdy` high) but does not appear on `out_vld`. A forwarded request to any other line is passed to `out_vld`/`out_tag` in the same cycle.
- R7: Starting in the cycle after completion, the parked requests of a line are presented on `out_vld`/`out_tag` one per cycle, in the order they arrived. While any release is in progress, `fwd_rdy` is low.
- R8: An acknowledgement that matches no entry waiting for data or acknowledgements produces a one-cycle `ack_err` pulse in the next cycle. It changes no entry's state.
- R9: After reset, all entries are free. `alloc_idx` is 0, and `grant_vld`, `inst_mask`, `ack_err` and `out_vld` are low. `fwd_rdy` is high.
- R10: A forwarded request to a held line whose parking queue already holds QD requests sees `fwd_rdy` low and is not taken.
- R11: Entries run independently. Completions of different entries in the same cycle set several bits of `inst_mask` together, and a completed entry becomes allocatable again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_vld | input | 1 | New read-exclusive miss to track |
| alloc_addr | input | AW | Line address of the new miss |
| alloc_rdy | output | 1 | A free entry exists |
| alloc_idx | output | IW | Entry that the next allocation takes |
| data_vld | input | 1 | Data reply received |
| data_addr | input | AW | Line address of the data reply |
| data_cnt | input | CW | Number of invalidations the home node sent |
| ack_vld | input | 1 | Invalidation acknowledgement received |
| ack_addr | input | AW | Line address of the acknowledgement |
| fwd_vld | input | 1 | Incoming forwarded request |
| fwd_addr | input | AW | Line address of the forwarded request |
| fwd_tag | input | TW | Identifier of the forwarded request |
| fwd_rdy | output | 1 | Forwarded request accepted this cycle |
| out_vld | output | 1 | Forwarded request leaving toward the cache |
| out_tag | output | TW | Identifier of the leaving request |
| wb_vld | input | 1 | Writeback or victimisation attempt |
| wb_addr | input | AW | Line address of the writeback |
| wb_stall | output | 1 | Writeback must wait |
| grant_vld | output | 1 | Line usable by the core (pulse) |
| grant_addr | output | AW | Address of the granted line |
| inst_mask | output | NE | Per-entry completion pulse, line now write-owned |
| ack_err | output | 1 | Acknowledgement matched no entry (pulse) |

## Verification
The counting function is swept over every invalidation count from 0 to 5, with every split of acknowledgements before and after the data reply. This separates a counter that only counts forward from data arrival from one that keeps early acknowledgements. It also checks exactly when the writeback stall rises and falls relative to each acknowledgement. A parking run fills one line's queue, lets an unrelated request pass by, and then checks the release order and that new input is blocked during the release. A four-entry run gives two entries their last event in the same cycle, and a stray acknowledgement checks the error path.

// File: rtl/iac_pkg.sv
package iac_pkg;

    // Life cycle of one tracked write miss
    typedef enum logic [1:0] {
        ST_FREE  = 2'd0,   // unused
        ST_WAIT  = 2'd1,   // request issued, no data yet
        ST_HOLD  = 2'd2,   // data in, acknowledgements still short
        ST_DRAIN = 2'd3    // complete, releasing parked forwards
    } ent_st_e;

endpackage

// File: rtl/iac_lowest.sv
module iac_lowest #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);

    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IW'(i);
            end
        end
        any      = |req;
        gnt      = '0;
        gnt[idx] = any;
    end

endmodule

// File: rtl/iac_fwd_queue.sv
module iac_fwd_queue #(
    parameter int TW = 4,
    parameter int QD = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [TW-1:0] din,
    input  logic          pop,
    output logic [TW-1:0] head,
    output logic          full,
    output logic          left
);

    localparam int PW   = (QD > 1) ? $clog2(QD) : 1;
    localparam int CNTW = $clog2(QD + 1);

    typedef struct packed {
        logic [QD-1:0][TW-1:0] mem;
        logic [PW-1:0]         wp;
        logic [PW-1:0]         rp;
        logic [CNTW-1:0]       cnt;
    } q_t;

    q_t r_q, r_d;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(QD - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        r_d  = r_q;
        head = r_q.mem[r_q.rp];
        full = (r_q.cnt == CNTW'(QD));
        if (push) begin
            r_d.mem[r_q.wp] = din;
            r_d.wp          = bump(r_q.wp);
        end
        if (pop) begin
            r_d.rp = bump(r_q.rp);
        end
        r_d.cnt = r_q.cnt + CNTW'(push) - CNTW'(pop);
        left    = (r_d.cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (r_q.cnt < CNTW'(QD)));

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (r_q.cnt != '0));

endmodule

// File: rtl/iac_entry.sv
module iac_entry
    import iac_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_en,
    input  logic [AW-1:0] alloc_addr,
    input  logic          data_vld,
    input  logic [AW-1:0] data_addr,
    input  logic [CW-1:0] data_cnt,
    input  logic          ack_vld,
    input  logic [AW-1:0] ack_addr,
    input  logic          q_left,
    output ent_st_e       st,
    output logic [AW-1:0] addr,
    output logic          ack_hit,
    output logic          data_hit,
    output logic          done
);

    localparam int SW = CW + 2;

    typedef struct packed {
        ent_st_e               st;
        logic [AW-1:0]         addr;
        logic signed [SW-1:0]  cnt;   // acks seen minus invalidations announced
    } ent_t;

    ent_t r_q, r_d;

    logic                 busy;
    logic signed [SW-1:0] inc;
    logic signed [SW-1:0] dec;
    logic signed [SW-1:0] cnt_sum;

    always_comb begin
        r_d      = r_q;
        busy     = (r_q.st == ST_WAIT) || (r_q.st == ST_HOLD);
        ack_hit  = ack_vld && busy && (r_q.addr == ack_addr);
        data_hit = data_vld && (r_q.st == ST_WAIT) && (r_q.addr == data_addr);
        inc      = ack_hit ? SW'(1) : '0;
        dec      = data_hit ? SW'(data_cnt) : '0;
        cnt_sum  = r_q.cnt + inc - dec;
        done     = busy && ((r_q.st == ST_HOLD) || data_hit) && (cnt_sum == '0);

        case (r_q.st)
            ST_FREE: begin
                if (alloc_en) begin
                    r_d.st   = ST_WAIT;
                    r_d.addr = alloc_addr;
                    r_d.cnt  = '0;
                end
            end
            ST_WAIT, ST_HOLD: begin
                r_d.cnt = cnt_sum;
                if (done) begin
                    r_d.st  = q_left ? ST_DRAIN : ST_FREE;
                    r_d.cnt = '0;
                end else if (data_hit) begin
                    r_d.st = ST_HOLD;
                end
            end
            ST_DRAIN: begin
                if (!q_left) begin
                    r_d.st = ST_FREE;
                end
            end
            default: r_d.st = ST_FREE;
        endcase

        st   = r_q.st;
        addr = r_q.addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_FREE, addr: '0, cnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    // R4
    zero_count_no_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_hit && (data_cnt == '0) && (r_q.cnt == '0) && !ack_hit) |=> (r_q.st != ST_HOLD));

    // R3
    hold_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HOLD) |-> ($past(r_q.st) == ST_HOLD || $past(data_hit)));

    // R7
    drain_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.st == ST_DRAIN) |-> $past(done));

    // R1
    free_is_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_FREE) |-> (r_q.cnt == '0));

endmodule

// File: rtl/iac_collector.sv
module iac_collector
    import iac_pkg::*;
#(
    parameter int NE = 4,
    parameter int AW = 16,
    parameter int CW = 4,
    parameter int TW = 4,
    parameter int QD = 4,
    parameter int IW = (NE > 1) ? $clog2(NE) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_vld,
    input  logic [AW-1:0] alloc_addr,
    output logic          alloc_rdy,
    output logic [IW-1:0] alloc_idx,
    input  logic          data_vld,
    input  logic [AW-1:0] data_addr,
    input  logic [CW-1:0] data_cnt,
    input  logic          ack_vld,
    input  logic [AW-1:0] ack_addr,
    input  logic          fwd_vld,
    input  logic [AW-1:0] fwd_addr,
    input  logic [TW-1:0] fwd_tag,
    output logic          fwd_rdy,
    output logic          out_vld,
    output logic [TW-1:0] out_tag,
    input  logic          wb_vld,
    input  logic [AW-1:0] wb_addr,
    output logic          wb_stall,
    output logic          grant_vld,
    output logic [AW-1:0] grant_addr,
    output logic [NE-1:0] inst_mask,
    output logic          ack_err
);

    typedef struct packed {
        logic          grant_vld;
        logic [AW-1:0] grant_addr;
        logic [NE-1:0] inst_mask;
        logic          ack_err;
    } top_t;

    top_t r_q, r_d;

    ent_st_e       st_v   [NE];
    logic [AW-1:0] addr_v [NE];
    logic [TW-1:0] head_v [NE];

    logic [NE-1:0] free_v, drain_v, hold_v;
    logic [NE-1:0] ack_hit_v, data_hit_v, done_v;
    logic [NE-1:0] fhit_v, whit_v, full_v, left_v;
    logic [NE-1:0] alloc_gnt, alloc_en_v, push_v, pop_v;
    logic [IW-1:0] drain_idx;
    logic          any_drain, any_fhit;

    iac_lowest #(.N(NE), .IW(IW)) u_alloc_pick (
        .req (free_v),
        .gnt (alloc_gnt),
        .idx (alloc_idx),
        .any (alloc_rdy)
    );

    iac_lowest #(.N(NE), .IW(IW)) u_drain_pick (
        .req (drain_v),
        .gnt (pop_v),
        .idx (drain_idx),
        .any (any_drain)
    );

    for (genvar g = 0; g < NE; g++) begin : g_ent
        assign free_v[g]     = (st_v[g] == ST_FREE);
        assign drain_v[g]    = (st_v[g] == ST_DRAIN);
        assign hold_v[g]     = (st_v[g] == ST_HOLD);
        assign fhit_v[g]     = fwd_vld && hold_v[g] && (addr_v[g] == fwd_addr);
        assign whit_v[g]     = wb_vld && hold_v[g] && (addr_v[g] == wb_addr);
        assign alloc_en_v[g] = alloc_vld && alloc_gnt[g];
        assign push_v[g]     = fwd_rdy && fhit_v[g];

        iac_entry #(.AW(AW), .CW(CW)) u_entry (
            .clk        (clk),
            .rst_n      (rst_n),
            .alloc_en   (alloc_en_v[g]),
            .alloc_addr (alloc_addr),
            .data_vld   (data_vld),
            .data_addr  (data_addr),
            .data_cnt   (data_cnt),
            .ack_vld    (ack_vld),
            .ack_addr   (ack_addr),
            .q_left     (left_v[g]),
            .st         (st_v[g]),
            .addr       (addr_v[g]),
            .ack_hit    (ack_hit_v[g]),
            .data_hit   (data_hit_v[g]),
            .done       (done_v[g])
        );

        iac_fwd_queue #(.TW(TW), .QD(QD)) u_queue (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push_v[g]),
            .din   (fwd_tag),
            .pop   (pop_v[g]),
            .head  (head_v[g]),
            .full  (full_v[g]),
            .left  (left_v[g])
        );
    end

    always_comb begin
        any_fhit = |fhit_v;
        fwd_rdy  = !any_drain && !(|(fhit_v & full_v));
        wb_stall = |whit_v;

        if (any_drain) begin
            out_vld = 1'b1;
            out_tag = head_v[drain_idx];
        end else begin
            out_vld = fwd_vld && fwd_rdy && !any_fhit;
            out_tag = fwd_tag;
        end

        r_d            = r_q;
        r_d.grant_vld  = |data_hit_v;
        if (|data_hit_v) begin
            r_d.grant_addr = data_addr;
        end
        r_d.inst_mask  = done_v;
        r_d.ack_err    = ack_vld && !(|ack_hit_v);

        grant_vld  = r_q.grant_vld;
        grant_addr = r_q.grant_addr;
        inst_mask  = r_q.inst_mask;
        ack_err    = r_q.ack_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R8
    ack_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_err |-> $past(ack_vld));

    // R2
    grant_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> $past(data_vld));

    // R6
    held_not_passed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_vld && fwd_rdy && any_fhit) |-> !out_vld);

    // R3
    inst_from_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|inst_mask) |-> $past(|(~free_v)));

endmodule

// File: tb/iac_collector_tb.sv
module iac_collector_tb;

    localparam int NE = 4;
    localparam int AW = 16;
    localparam int CW = 4;
    localparam int TW = 4;
    localparam int QD = 4;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          alloc_vld = 1'b0;
    logic [AW-1:0] alloc_addr = '0;
    logic          alloc_rdy;
    logic [IW-1:0] alloc_idx;
    logic          data_vld = 1'b0;
    logic [AW-1:0] data_addr = '0;
    logic [CW-1:0] data_cnt = '0;
    logic          ack_vld = 1'b0;
    logic [AW-1:0] ack_addr = '0;
    logic          fwd_vld = 1'b0;
    logic [AW-1:0] fwd_addr = '0;
    logic [TW-1:0] fwd_tag = '0;
    logic          fwd_rdy;
    logic          out_vld;
    logic [TW-1:0] out_tag;
    logic          wb_vld = 1'b0;
    logic [AW-1:0] wb_addr = '0;
    logic          wb_stall;
    logic          grant_vld;
    logic [AW-1:0] grant_addr;
    logic [NE-1:0] inst_mask;
    logic          ack_err;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #5 clk = ~clk;

    iac_collector #(.NE(NE), .AW(AW), .CW(CW), .TW(TW), .QD(QD), .IW(IW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .alloc_vld(alloc_vld), .alloc_addr(alloc_addr), .alloc_rdy(alloc_rdy), .alloc_idx(alloc_idx),
        .data_vld(data_vld), .data_addr(data_addr), .data_cnt(data_cnt),
        .ack_vld(ack_vld), .ack_addr(ack_addr),
        .fwd_vld(fwd_vld), .fwd_addr(fwd_addr), .fwd_tag(fwd_tag), .fwd_rdy(fwd_rdy),
        .out_vld(out_vld), .out_tag(out_tag),
        .wb_vld(wb_vld), .wb_addr(wb_addr), .wb_stall(wb_stall),
        .grant_vld(grant_vld), .grant_addr(grant_addr), .inst_mask(inst_mask), .ack_err(ack_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // one clock; afterwards registered outputs show the last cycle's inputs
    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [AW-1:0] a;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R9 reset state
        check("R9 alloc_rdy", alloc_rdy, 1);
        check("R9 alloc_idx", alloc_idx, 0);
        check("R9 grant_vld", grant_vld, 0);
        check("R9 inst_mask", inst_mask, 0);
        check("R9 ack_err", ack_err, 0);
        check("R9 out_vld", out_vld, 0);
        check("R9 fwd_rdy", fwd_rdy, 1);
        cyc();

        // Sweep: count n, k acks before data, n-k after
        for (int n = 0; n <= 5; n++) begin
            for (int k = 0; k <= n; k++) begin
                a = AW'(16'h0100 + n * 16 + k);
                alloc_vld = 1'b1; alloc_addr = a;
                #1;
                check("R1 alloc_rdy", alloc_rdy, 1);
                check("R1 alloc_idx", alloc_idx, 0);
                cyc();
                alloc_vld = 1'b0;
                wb_vld = 1'b1; wb_addr = a;
                for (int j = 0; j < k; j++) begin
                    ack_vld = 1'b1; ack_addr = a;
                    #1;
                    check("R5 no stall before data", wb_stall, 0);
                    cyc();
                    ack_vld = 1'b0;
                    check("R3 early ack accepted", ack_err, 0);
                end
                data_vld = 1'b1; data_addr = a; data_cnt = CW'(n);
                #1;
                check("R5 no stall before data", wb_stall, 0);
                cyc();
                data_vld = 1'b0;
                check("R2 grant_vld", grant_vld, 1);
                check("R2 grant_addr", grant_addr, a);
                check("R3/R4 inst at data", inst_mask, (n == k) ? 1 : 0);
                #1;
                check("R5/R4 stall after data", wb_stall, (n > k) ? 1 : 0);
                for (int j = 0; j < n - k; j++) begin
                    ack_vld = 1'b1; ack_addr = a;
                    cyc();
                    ack_vld = 1'b0;
                    check("R3 inst after ack", inst_mask, (j == n - k - 1) ? 1 : 0);
                    check("R2 grant single pulse", grant_vld, 0);
                    #1;
                    check("R5 stall while short", wb_stall, (j < n - k - 1) ? 1 : 0);
                end
                wb_vld = 1'b0;
                cyc();
            end
        end

        // Forward parking and release
        alloc_vld = 1'b1; alloc_addr = 16'h0AA0;
        cyc();
        alloc_vld = 1'b0;
        data_vld = 1'b1; data_addr = 16'h0AA0; data_cnt = 4'd2;
        cyc();
        data_vld = 1'b0;
        fwd_vld = 1'b1; fwd_addr = 16'h0AA0; fwd_tag = 4'd1;
        #1;
        check("R6 held fwd accepted", fwd_rdy, 1);
        check("R6 held fwd not passed", out_vld, 0);
        cyc();
        fwd_addr = 16'h0BB0; fwd_tag = 4'd7;
        #1;
        check("R6 other line passes", out_vld, 1);
        check("R6 other line tag", out_tag, 7);
        cyc();
        for (int t = 2; t <= 4; t++) begin
            fwd_addr = 16'h0AA0; fwd_tag = TW'(t);
            #1;
            check("R6 park accepted", fwd_rdy, 1);
            cyc();
        end
        fwd_tag = 4'd5;
        #1;
        check("R10 full queue refuses", fwd_rdy, 0);
        check("R10 nothing out", out_vld, 0);
        fwd_vld = 1'b0;
        ack_vld = 1'b1; ack_addr = 16'h0AA0;
        cyc();
        cyc();
        ack_vld = 1'b0;
        check("R3 parked line completes", inst_mask, 1);
        fwd_vld = 1'b1; fwd_addr = 16'h0BB0; fwd_tag = 4'd9;
        #1;
        check("R7 release vld", out_vld, 1);
        check("R7 release first tag", out_tag, 1);
        check("R7 input blocked", fwd_rdy, 0);
        for (int t = 2; t <= 4; t++) begin
            cyc();
            check("R7 release order", out_tag, t);
            check("R7 release vld", out_vld, 1);
            check("R7 input blocked", fwd_rdy, 0);
        end
        cyc();
        #1;
        check("R7 after release passes", out_vld, 1);
        check("R7 after release tag", out_tag, 9);
        check("R7 after release ready", fwd_rdy, 1);
        cyc();
        fwd_vld = 1'b0;
        cyc();

        // Stray acknowledgement
        ack_vld = 1'b1; ack_addr = 16'h0CC0;
        cyc();
        ack_vld = 1'b0;
        check("R8 ack_err", ack_err, 1);
        check("R8 no completion", inst_mask, 0);
        #1;
        check("R8 entries untouched", alloc_idx, 0);
        check("R8 entries untouched rdy", alloc_rdy, 1);
        cyc();
        check("R8 single pulse", ack_err, 0);

        // Four entries in parallel
        for (int e = 0; e < NE; e++) begin
            alloc_vld = 1'b1; alloc_addr = AW'(16'h0010 + e);
            #1;
            check("R1 lowest free", alloc_idx, e);
            cyc();
        end
        alloc_vld = 1'b0;
        #1;
        check("R1 all busy", alloc_rdy, 0);
        data_vld = 1'b1; data_addr = 16'h0012; data_cnt = 4'd0;
        cyc();
        check("R11 zero count entry 2", inst_mask, 4);
        check("R11 grant addr", grant_addr, 16'h0012);
        #1;
        check("R11 freed entry reusable", alloc_idx, 2);
        check("R11 freed entry rdy", alloc_rdy, 1);
        data_addr = 16'h0011; data_cnt = 4'd1;
        cyc();
        data_addr = 16'h0010; data_cnt = 4'd1;
        cyc();
        data_vld = 1'b0;
        ack_vld = 1'b1; ack_addr = 16'h0011;
        cyc();
        check("R11 entry 1 done", inst_mask, 2);
        ack_addr = 16'h0010;
        data_vld = 1'b1; data_addr = 16'h0013; data_cnt = 4'd0;
        cyc();
        ack_vld = 1'b0; data_vld = 1'b0;
        check("R11 two completions", inst_mask, 9);
        check("R11 grant addr", grant_addr, 16'h0013);
        cyc();
        check("R1 all free again", alloc_idx, 0);
        check("R11 pulse ends", inst_mask, 0);

        finish_run();
    end

endmodule